// File: doc/BRIEF.md
# Ethernet Receive FIFO Front-End

This block is the receive side of a polled Ethernet MAC, as seen from the host. Received frame bytes arrive one per cycle on a byte stream, with a marker on the final byte. The block packs them into 32-bit words, most significant byte first, and queues the complete words in a small word FIFO. The final word of every frame is held apart in a single tail register. It may hold one, two, three or four bytes.

When the final byte has been taken, the block raises a buffer-ready flag. It also publishes the frame size in bytes, which counts the 4-byte frame check sequence the byte stream carries. A separate field gives the number of valid bytes in the tail word. The host reads the frame through one data port, one word per read strobe: first the queued words, then the tail word. It then frees the buffer with a write-one-to-clear strobe.

The block detects overrun in two cases: when a frame needs more queue room than exists, and when bytes arrive while a frame is still waiting for the host. Dropping the receive enable flushes everything and clears the overrun flag. This is how the host restarts the receive path after an overrun.

Top module: `eth_rx_fifo_fe`

## Requirements
- R1: Frame bytes are packed into 32-bit words in arrival order, with the first byte of each word in bits 31:24 and the fourth in bits 7:0. Successive data-port reads return the frame's words in arrival order.
- R2: The edge that accepts the final byte of a frame sets the buffer-ready flag, which is bit 0 of `gen_stat`. From that same edge, bits 31:16 of `rx_stat` give the frame size in bytes, counting every byte received, the frame check sequence included.
- R3: While the buffer-ready flag is clear, the reported size is 0 and `rd_data` is 0. A read strobe in that state removes nothing.
- R4: The final word of a frame waits in the tail stage. Bit 1 of `gen_stat` is set while that word is unread, and bits 31:28 give its valid byte count, 1 to 4. The valid bytes sit in the high positions and the unused low bytes read as zero. The tail word is returned after the queued words, and reading it clears bit 1. Any further read returns 0.
- R5: A pulse on `rdy_clr` while the buffer-ready flag is set clears the flag and discards any unread words of that frame.
- R6: If a complete word must be queued while the word FIFO already holds DEPTH words, the overrun flag (bit 0 of `rx_stat`) is set. The frame is dropped without raising buffer-ready, and its remaining bytes are ignored up to its final byte. The next frame is received normally.
- R7: Bytes that arrive while the buffer-ready flag is set are ignored, up to the final byte of their frame, and set the overrun flag. The stored frame, its size and its data stay intact.
- R8: While `rx_en` is low, all input bytes are ignored. One cycle with `rx_en` low clears the overrun flag, the buffer-ready flag, the tail stage and the word FIFO.
- R9: After reset, `rd_data`, `rx_stat` and `gen_stat` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low flushes the receive path |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Received frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| rd_en | input | 1 | Data-port read strobe, one word per cycle |
| rdy_clr | input | 1 | Write-one-to-clear of the buffer-ready flag |
| rd_data | output | 32 | Data-port word |
| rx_stat | output | 32 | Frame size in bits 31:16, overrun flag in bit 0 |
| gen_stat | output | 32 | Tail byte count in bits 31:28, tail pending in bit 1, buffer ready in bit 0 |

## Verification
Every status result is registered, so each one is due at the clock edge that samples the triggering input. That edge is the final byte for ready, size and tail count, the overflowing byte for overrun, and the strobe itself for a clear or a flush. The bench drives inputs on falling edges and checks at the next falling edge, half a cycle after the edge concerned. The data port is combinational from the stored state, so each word is checked during the falling-edge half of the cycle its read strobe is high. The pop then takes effect at the following rising edge. A sweep of every frame length the default queue holds covers all four tail byte counts against arithmetically built words.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / BYTE_W;
    localparam int LANE_W     = $clog2(LANES);
    localparam int LEN_W      = 16;
    localparam int CNT_FLD_W  = 4;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [LANE_W-1:0]  lane_t;
    typedef logic [LEN_W-1:0]   len_t;

    // final word of a frame plus its valid byte count
    typedef struct packed {
        logic [CNT_FLD_W-1:0] nbytes;
        word_t                data;
    } tail_t;

    // drop byte b into lane slot, slot 0 being the most significant byte
    function automatic word_t place_byte(word_t acc, byte_t b, lane_t slot);
        word_t shifted;
        shifted = word_t'(b) << (BYTE_W * (LANES - 1 - int'(slot)));
        return acc | shifted;
    endfunction

endpackage

// File: rtl/rxf_packer.sv
module rxf_packer
    import rxf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 vld,
    input  byte_t                byte_in,
    input  logic                 last,
    output word_t                word_out,
    output logic [CNT_FLD_W-1:0] nbytes,
    output logic                 word_full
);

    word_t acc_q;
    lane_t slot_q;

    always_comb begin
        word_out  = place_byte(acc_q, byte_in, slot_q);
        nbytes    = CNT_FLD_W'(slot_q) + CNT_FLD_W'(1);
        word_full = (slot_q == lane_t'(LANES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q  <= '0;
            slot_q <= '0;
        end else if (vld) begin
            if (word_full || last) begin
                acc_q  <= '0;
                slot_q <= '0;
            end else begin
                acc_q  <= word_out;
                slot_q <= slot_q + lane_t'(1);
            end
        end
    end

endmodule

// File: rtl/rxf_word_fifo.sv
module rxf_word_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  push,
    input  word_t push_data,
    input  logic  pop,
    output word_t head,
    output logic  full,
    output logic  empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    word_t           mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   count;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign head  = mem[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (push && !full && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop && !empty) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push && !full, pop && !empty})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/eth_rx_fifo_fe.sv
module eth_rx_fifo_fe
    import rxf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_en,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic        rd_en,
    input  logic        rdy_clr,
    output logic [31:0] rd_data,
    output logic [31:0] rx_stat,
    output logic [31:0] gen_stat
);

    // frame control state
    logic  ready_q;
    logic  ovr_q;
    logic  drop_q;
    len_t  len_acc_q;
    len_t  len_q;
    tail_t tail_q;
    logic  tail_pend_q;

    // packer and queue wiring
    word_t                pk_word;
    logic [CNT_FLD_W-1:0] pk_nbytes;
    logic                 pk_full;
    word_t                fifo_head;
    logic                 fifo_full;
    logic                 fifo_empty;

    logic en_byte, busy_hit, take, need_push, overflow;
    logic fifo_push, fifo_pop, fifo_flush, tail_take, rd_hit, free_buf;

    always_comb begin
        en_byte    = in_valid && rx_en;
        busy_hit   = en_byte && ready_q && !drop_q;
        take       = en_byte && !ready_q && !drop_q;
        need_push  = take && pk_full && !in_last;
        overflow   = need_push && fifo_full;
        fifo_push  = need_push && !fifo_full;
        rd_hit     = rd_en && ready_q;
        fifo_pop   = rd_hit && !fifo_empty;
        tail_take  = rd_hit && fifo_empty && tail_pend_q;
        free_buf   = rdy_clr && ready_q;
        fifo_flush = !rx_en || overflow || free_buf;
    end

    rxf_packer u_packer (
        .clk       (clk),
        .rst       (rst),
        .clear     (!rx_en || overflow),
        .vld       (take && !overflow),
        .byte_in   (in_data),
        .last      (in_last),
        .word_out  (pk_word),
        .nbytes    (pk_nbytes),
        .word_full (pk_full)
    );

    rxf_word_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (fifo_flush),
        .push      (fifo_push),
        .push_data (pk_word),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            ready_q     <= 1'b0;
            ovr_q       <= 1'b0;
            drop_q      <= 1'b0;
            len_acc_q   <= '0;
            len_q       <= '0;
            tail_q      <= '0;
            tail_pend_q <= 1'b0;
        end else begin
            if (overflow) begin
                ovr_q     <= 1'b1;
                drop_q    <= 1'b1;
                len_acc_q <= '0;
            end else if (busy_hit) begin
                ovr_q  <= 1'b1;
                drop_q <= !in_last;
            end else if (en_byte && drop_q) begin
                if (in_last) begin
                    drop_q <= 1'b0;
                end
            end else if (take) begin
                if (in_last) begin
                    ready_q     <= 1'b1;
                    len_q       <= len_acc_q + len_t'(1);
                    len_acc_q   <= '0;
                    tail_q      <= '{nbytes: pk_nbytes, data: pk_word};
                    tail_pend_q <= 1'b1;
                end else begin
                    len_acc_q <= len_acc_q + len_t'(1);
                end
            end

            if (tail_take) begin
                tail_pend_q <= 1'b0;
            end
            if (free_buf) begin
                ready_q     <= 1'b0;
                tail_pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (!ready_q) begin
            rd_data = '0;
        end else if (!fifo_empty) begin
            rd_data = fifo_head;
        end else if (tail_pend_q) begin
            rd_data = tail_q.data;
        end else begin
            rd_data = '0;
        end
        rx_stat  = {(ready_q ? len_q : len_t'(0)), 15'd0, ovr_q};
        gen_stat = {(ready_q ? tail_q.nbytes : 4'd0), 26'd0, tail_pend_q, ready_q};
    end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic        clk,
    input logic        rst,
    input logic        rx_en,
    input logic        rdy_clr,
    input logic [31:0] rd_data,
    input logic [31:0] rx_stat,
    input logic [31:0] gen_stat
);

    AST_READY_HAS_LEN: assert property (@(posedge clk) disable iff (rst)
        gen_stat[0] |-> rx_stat[31:16] != 16'd0);                      // R2

    AST_IDLE_LEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        !gen_stat[0] |-> rx_stat[31:16] == 16'd0);                     // R3

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !gen_stat[0] |-> rd_data == 32'd0);                            // R3

    AST_TAIL_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        gen_stat[0] |-> (gen_stat[31:28] >= 4'd1 && gen_stat[31:28] <= 4'd4)); // R4

    AST_TAIL_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        gen_stat[1] |-> gen_stat[0]);                                  // R4

    AST_CLEAR_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (gen_stat[0] && rdy_clr && rx_en) |=> !gen_stat[0]);            // R5

    AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (rx_stat == 32'd0 && gen_stat == 32'd0));           // R8

endmodule

bind eth_rx_fifo_fe rxf_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .rdy_clr  (rdy_clr),
    .rd_data  (rd_data),
    .rx_stat  (rx_stat),
    .gen_stat (gen_stat)
);

// File: tb/eth_rx_fifo_fe_tb.sv
`timescale 1ns/1ps
module eth_rx_fifo_fe_tb;

    localparam int DEPTH   = 8;
    localparam int MAX_LEN = 4 * DEPTH + 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        in_last = 1'b0;
    logic        rd_en = 1'b0;
    logic        rdy_clr = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] rx_stat;
    logic [31:0] gen_stat;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    eth_rx_fifo_fe #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .rd_en(rd_en),
        .rdy_clr(rdy_clr), .rd_data(rd_data), .rx_stat(rx_stat),
        .gen_stat(gen_stat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int seed, input int i);
        return 8'((seed * 29 + i * 13 + 1) & 255);
    endfunction

    function automatic logic [31:0] exp_word(input int seed, input int len, input int k);
        logic [31:0] w = '0;
        for (int j = 0; j < 4; j++) begin
            if (4 * k + j < len) w |= 32'(fbyte(seed, 4 * k + j)) << (8 * (3 - j));
        end
        return w;
    endfunction

    // all tasks start and end just after a falling edge
    task automatic send_frame(input int seed, input int len);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = fbyte(seed, i);
            in_last  = (i == len - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic read_word(output logic [31:0] w);
        rd_en = 1'b1;
        #1 w = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear_ready();
        rdy_clr = 1'b1;
        @(negedge clk);
        rdy_clr = 1'b0;
    endtask

    task automatic drain_check(input int seed, input int len, input string req);
        logic [31:0] w;
        int nw = (len + 3) / 4;
        for (int k = 0; k < nw; k++) begin
            read_word(w);
            check(req, w, exp_word(seed, len, k));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 rd_data", rd_data, 0);
        check("R9 rx_stat", rx_stat, 0);
        check("R9 gen_stat", gen_stat, 0);
        rx_en = 1'b1;
        @(negedge clk);

        // R3 read with no frame
        read_word(w);
        check("R3 idle read", w, 0);
        check("R3 idle size", {16'd0, rx_stat[31:16]}, 0);

        // R1 R2 R4 sweep every length that fits
        for (int len = 1; len <= MAX_LEN; len++) begin
            send_frame(len, len);
            check("R2 ready", {31'd0, gen_stat[0]}, 1);
            check("R2 size", {16'd0, rx_stat[31:16]}, 32'(len));
            check("R4 tail count", {28'd0, gen_stat[31:28]}, 32'((len - 1) % 4 + 1));
            check("R4 tail pending", {31'd0, gen_stat[1]}, 1);
            check("R6 no overrun", {31'd0, rx_stat[0]}, 0);
            drain_check(len, len, "R1 word");
            check("R4 tail consumed", {31'd0, gen_stat[1]}, 0);
            read_word(w);
            check("R4 read past end", w, 0);
            clear_ready();
            check("R5 ready cleared", {31'd0, gen_stat[0]}, 0);
            check("R3 size zero", {16'd0, rx_stat[31:16]}, 0);
        end

        // R5 clear discards unread words
        send_frame(3, 12);
        read_word(w);
        check("R5 first word", w, exp_word(3, 12, 0));
        clear_ready();
        check("R5 discarded read", rd_data, 0);
        send_frame(4, 4);
        drain_check(4, 4, "R5 fresh frame");
        clear_ready();

        // R6 overrun on oversize frame
        send_frame(5, MAX_LEN + 1);
        check("R6 overrun set", {31'd0, rx_stat[0]}, 1);
        check("R6 no ready", {31'd0, gen_stat[0]}, 0);
        send_frame(6, MAX_LEN + 4);
        check("R6 no ready long", {31'd0, gen_stat[0]}, 0);
        send_frame(7, 5);
        check("R6 next frame ready", {31'd0, gen_stat[0]}, 1);
        check("R6 next frame size", {16'd0, rx_stat[31:16]}, 5);
        drain_check(7, 5, "R6 next frame data");
        clear_ready();

        // R8 enable low clears overrun and ignores bytes
        rx_en = 1'b0;
        send_frame(8, 3);
        check("R8 overrun cleared", {31'd0, rx_stat[0]}, 0);
        check("R8 bytes ignored", gen_stat, 0);
        rx_en = 1'b1;
        @(negedge clk);
        send_frame(9, 7);
        rx_en = 1'b0;
        @(negedge clk);
        check("R8 flush ready", gen_stat, 0);
        rx_en = 1'b1;
        @(negedge clk);

        // R7 bytes arriving while a frame waits
        send_frame(10, 6);
        send_frame(11, 3);
        check("R7 overrun", {31'd0, rx_stat[0]}, 1);
        check("R7 size kept", {16'd0, rx_stat[31:16]}, 6);
        drain_check(10, 6, "R7 data kept");
        clear_ready();
        send_frame(12, 2);
        check("R7 later frame size", {16'd0, rx_stat[31:16]}, 2);
        drain_check(12, 2, "R7 later frame data");
        clear_ready();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule